// File: doc/BRIEF.md
# Four-Channel DAC Command Register Controller

This block is the digital register core of a four-channel voltage-output converter. It takes one 24-bit command word per cycle, qualified by a valid strobe. For each channel it holds a staging (input) register, a live output-code register and a two-bit power mode. A four-bit auto-update mask is shared by the channels. The output codes and power modes are registered, so they change on the clock edge that accepts a frame and can be seen from the following cycle.

The two-stage register arrangement lets software stage new codes on several channels and then make them take effect together. It can do this with an explicit copy command, a write that refreshes every channel, a write-through, or the auto-update mask. A masked power command changes only the power mode of the selected channels. A soft reset has a partial level and a full level. The parameter `CODE_W` selects 16-bit or 12-bit output codes.

Top module: `dac_reg_ctrl`

## Requirements
- R1: Word layout: bits 21:19 are the opcode, bits 18:16 the channel select and bits 15:0 the data. Bits 23:22 are ignored. A word is acted on only in a cycle with `frame_valid` high; its effect is visible at the outputs from the next cycle. With `frame_valid` low nothing changes.
- R2: Channel select 000..011 picks channel 0..3 and 111 picks all four. A frame with select 100, 101 or 110 changes no state, whatever its opcode.
- R3: Opcode 000 loads the data code into the staging register of each selected channel. It does not change that channel's output code, except through auto-update (R8).
- R4: Opcode 001 copies the staging register of each selected channel into its output code.
- R5: Opcode 010 loads the selected staging registers and then copies all four staging registers, with their new values, into the output codes.
- R6: Opcode 011 loads the data code into both registers of each selected channel.
- R7: Opcode 100 writes data bits 5:4 into the power mode of every channel whose bit in data 3:0 is 1 (bit i is channel i). Mode 00 is normal, 01 is 1k to ground, 10 is 100k to ground and 11 is high impedance. Output codes are unchanged.
- R8: Opcode 110 loads data 3:0 into the auto-update mask. On every accepted frame other than a reset, each channel whose mask bit is 1 copies its (new) staging value into its output code. The mask used is the one in force before that frame.
- R9: Opcode 101 clears every staging and output code register. When data bit 0 is 1 it also clears all power modes and the auto-update mask.
- R10: Opcode 111 changes no state.
- R11: After the synchronous active-high reset, all output codes, power modes, staging registers and the auto-update mask are zero.
- R12: With `CODE_W` = 12 the code is taken from data bits 15:4, and data bits 3:0 are ignored. With `CODE_W` = 16 all 16 data bits form the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | Qualifies `frame_word` for this cycle |
| frame_word | input | 24 | Command word: opcode, channel select, data |
| dac_code | output | 4*CODE_W | Output codes; channel i at bits [i*CODE_W +: CODE_W] |
| pwr_mode | output | 8 | Power modes; channel i at bits [2*i +: 2] |

## Verification
The auto-update path and an explicit command can both act on an output code in the same cycle. This happens when a staged write, a write-through, a broadcast-update write or a power command arrives while mask bits are set. In that case the output code must end up at the staging register's new value, not its old one. The bench sets random masks and sends random opcodes in a long stream, so these overlaps happen often. After every frame, a bench-side model of all registers judges the outputs. Directed frames cover the other overlap: a full reset that arrives while the mask is set must win over the auto-update copy.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int WORD_W = 24;
  localparam int NUM_CH = 4;
  localparam int MODE_W = 2;

  typedef enum logic [2:0] {
    OP_WR_IN   = 3'd0,
    OP_UPD     = 3'd1,
    OP_WR_BCST = 3'd2,
    OP_WR_THRU = 3'd3,
    OP_POWER   = 3'd4,
    OP_RESET   = 3'd5,
    OP_AUTO    = 3'd6,
    OP_RSVD    = 3'd7
  } op_e;

  localparam logic [2:0] SEL_ALL = 3'b111;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_ctrl_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic                frame_valid,
  input  logic [WORD_W-1:0]   frame_word,
  output logic                frame_ok,
  output logic [NUM_CH-1:0]   wr_mask,
  output logic [NUM_CH-1:0]   upd_mask,
  output logic [NUM_CH-1:0]   pd_mask,
  output logic [MODE_W-1:0]   pd_mode,
  output logic                clr_data,
  output logic                clr_all,
  output logic                auto_load,
  output logic [NUM_CH-1:0]   auto_data,
  output logic [CODE_W-1:0]   code
);
  localparam int DATA_W = 16;

  op_e               op;
  logic [2:0]        sel;
  logic [DATA_W-1:0] data;
  logic              sel_ok;
  logic [NUM_CH-1:0] hit;

  assign op   = op_e'(frame_word[21:19]);
  assign sel  = frame_word[18:16];
  assign data = frame_word[DATA_W-1:0];
  assign code = data[DATA_W-1 -: CODE_W];

  assign sel_ok   = (sel < 3'(NUM_CH)) || (sel == SEL_ALL);
  assign frame_ok = frame_valid && sel_ok && (op != OP_RSVD);

  always_comb begin
    if (sel == SEL_ALL) hit = '1;
    else if (sel < 3'(NUM_CH)) hit = NUM_CH'(1) << sel[1:0];
    else hit = '0;
  end

  always_comb begin
    wr_mask   = '0;
    upd_mask  = '0;
    pd_mask   = '0;
    pd_mode   = data[5:4];
    clr_data  = 1'b0;
    clr_all   = 1'b0;
    auto_load = 1'b0;
    auto_data = data[NUM_CH-1:0];
    if (frame_ok) begin
      unique case (op)
        OP_WR_IN:   wr_mask = hit;
        OP_UPD:     upd_mask = hit;
        OP_WR_BCST: begin wr_mask = hit; upd_mask = '1; end
        OP_WR_THRU: begin wr_mask = hit; upd_mask = hit; end
        OP_POWER:   pd_mask = data[NUM_CH-1:0];
        OP_RESET:   begin clr_data = 1'b1; clr_all = data[0]; end
        OP_AUTO:    auto_load = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/dac_auto_mask.sv
module dac_auto_mask
  import dac_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_all,
  input  logic              load,
  input  logic [NUM_CH-1:0] load_data,
  output logic [NUM_CH-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst || clr_all) mask_q <= '0;
    else if (load) mask_q <= load_data;
  end

  AST_AUTO_FULL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> mask_q == '0); // R9
  AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !clr_all) |=> $stable(mask_q)); // R8
endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dac_ctrl_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              upd_en,
  input  logic              clr_data,
  input  logic              pd_en,
  input  logic              clr_mode,
  input  logic [CODE_W-1:0] code_in,
  input  logic [MODE_W-1:0] mode_in,
  output logic [CODE_W-1:0] code_out,
  output logic [MODE_W-1:0] mode_out
);
  logic [CODE_W-1:0] stage_q, stage_nxt, live_q;
  logic [MODE_W-1:0] mode_q;

  always_comb begin
    if (clr_data) stage_nxt = '0;
    else if (wr_en) stage_nxt = code_in;
    else stage_nxt = stage_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      live_q  <= '0;
      mode_q  <= '0;
    end else begin
      stage_q <= stage_nxt;
      if (clr_data) live_q <= '0;
      else if (upd_en) live_q <= stage_nxt;
      if (clr_mode) mode_q <= '0;
      else if (pd_en) mode_q <= mode_in;
    end
  end

  assign code_out = live_q;
  assign mode_out = mode_q;

  AST_CLEAR_CODE: assert property (@(posedge clk) disable iff (rst)
    clr_data |=> code_out == '0); // R9
  AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (rst)
    (pd_en && !upd_en && !clr_data) |=> $stable(code_out)); // R7
  AST_THRU_CODE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && upd_en && !clr_data) |=> code_out == $past(code_in)); // R6
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pd_en && !clr_mode) |=> $stable(mode_out)); // R7
endmodule

// File: rtl/dac_reg_ctrl.sv
module dac_reg_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_valid,
  input  logic [WORD_W-1:0]          frame_word,
  output logic [NUM_CH*CODE_W-1:0]   dac_code,
  output logic [NUM_CH*MODE_W-1:0]   pwr_mode
);
  logic              frame_ok, clr_data, clr_all, auto_load;
  logic [NUM_CH-1:0] wr_mask, upd_mask, pd_mask, auto_data, auto_q;
  logic [MODE_W-1:0] pd_mode;
  logic [CODE_W-1:0] code;

  initial begin
    if (CODE_W != 16 && CODE_W != 12) $error("CODE_W must be 12 or 16");
  end

  dac_cmd_decode #(.CODE_W(CODE_W)) u_dec (
    .frame_valid(frame_valid), .frame_word(frame_word), .frame_ok(frame_ok),
    .wr_mask(wr_mask), .upd_mask(upd_mask), .pd_mask(pd_mask), .pd_mode(pd_mode),
    .clr_data(clr_data), .clr_all(clr_all), .auto_load(auto_load),
    .auto_data(auto_data), .code(code)
  );

  dac_auto_mask u_auto (
    .clk(clk), .rst(rst), .clr_all(clr_all), .load(auto_load),
    .load_data(auto_data), .mask_q(auto_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic upd_i;
    assign upd_i = upd_mask[i] | (auto_q[i] & frame_ok & ~clr_data);

    dac_channel #(.CODE_W(CODE_W)) u_ch (
      .clk(clk), .rst(rst), .wr_en(wr_mask[i]), .upd_en(upd_i),
      .clr_data(clr_data), .pd_en(pd_mask[i]), .clr_mode(clr_all),
      .code_in(code), .mode_in(pd_mode),
      .code_out(dac_code[i*CODE_W +: CODE_W]),
      .mode_out(pwr_mode[i*MODE_W +: MODE_W])
    );
  end

  AST_RESERVED_NOP: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && frame_word[21:19] == 3'b111)
      |=> ($stable(dac_code) && $stable(pwr_mode))); // R10
  AST_BAD_SEL_NOP: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && frame_word[18:16] inside {3'd4, 3'd5, 3'd6})
      |=> ($stable(dac_code) && $stable(pwr_mode))); // R2
  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |=> ($stable(dac_code) && $stable(pwr_mode))); // R1
  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && pwr_mode == '0)); // R11
endmodule

// File: tb/tb_dac_reg_ctrl.sv
module tb_dac_reg_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_valid = 1'b0;
  logic [23:0] frame_word = '0;
  logic [63:0] dac_code;
  logic [47:0] dac_code_n;
  logic [7:0]  pwr_mode;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] m_in [4];
  logic [15:0] m_dac [4];
  logic [1:0]  m_pm [4];
  logic [3:0]  m_auto;

  always #2 clk = ~clk;

  dac_reg_ctrl #(.CODE_W(16)) dut (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_word(frame_word),
    .dac_code(dac_code), .pwr_mode(pwr_mode)
  );

  dac_reg_ctrl #(.CODE_W(12)) dut_n12 (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_word(frame_word),
    .dac_code(dac_code_n), .pwr_mode()
  );

  function automatic logic [23:0] mk(input logic [2:0] op, input logic [2:0] sel,
                                     input logic [15:0] d);
    return {2'b00, op, sel, d};
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 4; i++) begin
      m_in[i] = '0; m_dac[i] = '0; m_pm[i] = '0;
    end
    m_auto = '0;
  endfunction

  function automatic void model_apply(input logic [23:0] w);
    logic [2:0] op, sel;
    logic [15:0] d;
    logic [3:0] hit, old_auto;
    op = w[21:19]; sel = w[18:16]; d = w[15:0];
    if (op == 3'd7 || sel inside {3'd4, 3'd5, 3'd6}) return;
    hit = (sel == 3'd7) ? 4'hF : (4'b1 << sel[1:0]);
    old_auto = m_auto;
    for (int i = 0; i < 4; i++) begin
      case (op)
        3'd0: if (hit[i]) m_in[i] = d;
        3'd1: if (hit[i]) m_dac[i] = m_in[i];
        3'd2: if (hit[i]) m_in[i] = d;
        3'd3: if (hit[i]) begin m_in[i] = d; m_dac[i] = d; end
        3'd4: if (d[i]) m_pm[i] = d[5:4];
        3'd5: begin
          m_in[i] = '0; m_dac[i] = '0;
          if (d[0]) m_pm[i] = '0;
        end
        default: ;
      endcase
    end
    if (op == 3'd2) for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
    if (op == 3'd6) m_auto = d[3:0];
    if (op == 3'd5 && d[0]) m_auto = '0;
    if (op != 3'd5) for (int i = 0; i < 4; i++) if (old_auto[i]) m_dac[i] = m_in[i];
  endfunction

  function automatic logic [63:0] exp_code();
    return {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
  endfunction

  function automatic logic [47:0] exp_narrow();
    return {m_dac[3][15:4], m_dac[2][15:4], m_dac[1][15:4], m_dac[0][15:4]};
  endfunction

  function automatic logic [7:0] exp_mode();
    return {m_pm[3], m_pm[2], m_pm[1], m_pm[0]};
  endfunction

  function automatic string tag_of(input logic [23:0] w);
    if (w[18:16] inside {3'd4, 3'd5, 3'd6}) return "R2";
    case (w[21:19])
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R9";
      3'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "codes", dac_code, exp_code());
    chk(tag, "modes", {56'd0, pwr_mode}, {56'd0, exp_mode()});
    chk("R12", "narrow codes", {16'd0, dac_code_n}, {16'd0, exp_narrow()});
  endtask

  task automatic send(input logic [23:0] w);
    @(negedge clk);
    frame_valid = 1'b1;
    frame_word  = w;
    @(negedge clk);
    frame_valid = 1'b0;
    frame_word  = 24'($urandom);
    model_apply(w);
    compare(tag_of(w));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R11");                              // R11 reset state

    send(mk(3'd0, 3'd1, 16'h1234));              // R3 staged write, output stays 0
    send(mk(3'd1, 3'd1, 16'h0000));              // R4 copy staging to output
    send(mk(3'd0, 3'd2, 16'hABCD));              // R3
    send(mk(3'd2, 3'd0, 16'h5A5F));              // R5 broadcast after write
    send(mk(3'd3, 3'd7, 16'hFFFF));              // R6 write-through all
    send(mk(3'd4, 3'd0, 16'h0025));              // R7 mode 10 on ch0, ch2
    send(mk(3'd4, 3'd3, 16'h003A));              // R7 mode 11 on ch1, ch3
    send({2'b11, 3'd0, 3'd3, 16'h0F0F});         // R1 top bits ignored

    // R1: word held with valid low changes nothing
    @(negedge clk);
    frame_word = mk(3'd3, 3'd7, 16'h1111);
    @(negedge clk);
    @(negedge clk);
    compare("R1");

    send(mk(3'd6, 3'd0, 16'h0005));              // R8 load mask 0101
    send(mk(3'd0, 3'd0, 16'h2222));              // R8 auto copy with staged write
    send(mk(3'd4, 3'd0, 16'h0001));              // R8 power frame triggers copy
    send(mk(3'd3, 3'd5, 16'h7777));              // R2 unused select
    send(mk(3'd7, 3'd0, 16'h9999));              // R10 reserved
    send(mk(3'd5, 3'd0, 16'h0000));              // R9 partial reset keeps modes, mask
    send(mk(3'd0, 3'd2, 16'h4444));              // R8 mask survived partial reset
    send(mk(3'd5, 3'd7, 16'h0001));              // R9 full reset
    send(mk(3'd0, 3'd0, 16'h3333));              // R9 mask cleared, no copy
    send(mk(3'd3, 3'd1, 16'hFFF7));              // R12 low nibble dropped in 12-bit

    for (int k = 0; k < 600; k++) begin
      logic [2:0] op, sel;
      logic [15:0] d;
      op  = 3'($urandom);
      sel = ($urandom % 8 == 0) ? 3'($urandom) : (($urandom % 5 == 4) ? 3'd7 : 3'($urandom % 4));
      if (op == 3'd5 && ($urandom % 4 != 0)) op = 3'd0;
      d = 16'($urandom);
      send(mk(op, sel, d));
      if ($urandom % 3 == 0) begin
        @(negedge clk);
        compare("R1");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule